// File: doc/BRIEF.md
# Loop Requeue Controller

This controller sits at the write side of a circular instruction FIFO and decides what enters it. It has three streams, each with a valid/ready handshake. The first is a load stream of new instructions. The second is a return stream of instructions that have left execution. The third is a single stream into the FIFO. The controller has two modes. In loading mode, new instructions flow into the FIFO and returning instructions from an earlier loop are dropped. In looping mode, returning instructions are fed back into the FIFO, and the loaded body runs again and again.

Two marker instructions control the change of mode. A loop-end marker on the load stream stops and waits. A loop-start marker on the return stream also stops and waits. Looping mode starts only when both markers wait together. Both markers are then consumed and neither enters the FIFO. A qualified abort pulse comes from the execution stage, with its predicate already evaluated. The abort ends looping mode. It also blocks a rendezvous in the same cycle.

All paths are combinational pass-throughs with no storage. The only register is the mode bit.

Top module: `loop_requeue_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `loop_active` is 0 (loading mode).
- R2: In loading mode, a load-stream item that is not a loop-end marker is presented on the output with its data unchanged, and `load_ready` follows `fifo_ready`.
- R3: In loading mode, a return-stream item that is not a loop-start marker is accepted (`ret_ready`=1) and does not appear on the output.
- R4: In loading mode, a loop-end marker on the load stream is held (`load_ready`=0 and no output) and a loop-start marker on the return stream is held (`ret_ready`=0), unless R5 applies in that cycle.
- R5: In loading mode, a loop-end marker valid on the load stream together with a loop-start marker valid on the return stream, with no abort, consumes both in that cycle (both readies 1, no output), and `loop_active` is 1 from the next cycle.
- R6: In looping mode, `load_ready` is 0. Each return-stream item, marker or not, passes to the output unchanged, and `ret_ready` follows `fifo_ready`.
- R7: An abort pulse in looping mode makes `loop_active` 0 from the next cycle. An abort in loading mode without a rendezvous changes nothing.
- R8: An abort in the same cycle as a rendezvous wins: the mode stays loading and both markers stay held (both readies 0).
- R9: In loading mode, dropping a return item and forwarding a load item can complete in the same cycle.
- R10: Marker decode uses instruction bits 21:18 only. 4'b1110 is the loop-start marker and 4'b1111 is the loop-end marker. Any other code is an ordinary instruction, and a marker code on the stream where it has no meaning is treated as ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Load stream item valid |
| load_data | input | 25 | Load stream instruction |
| load_ready | output | 1 | Load stream item accepted |
| ret_valid | input | 1 | Return stream item valid |
| ret_data | input | 25 | Return stream instruction |
| ret_ready | output | 1 | Return stream item accepted |
| fifo_valid | output | 1 | Output item valid |
| fifo_data | output | 25 | Output instruction |
| fifo_ready | input | 1 | FIFO can take an item |
| abort_pulse | input | 1 | Qualified abort, one cycle |
| loop_active | output | 1 | 1 in looping mode, 0 in loading mode |

## Verification
Two pairs of functions can fall in the same cycle.

- **Drop and forward:** a return-stream drop can coincide with a load-stream forward. The bench drives an ordinary item on both streams with the FIFO ready. It expects both readies high and only the load item on the output.
- **Abort and rendezvous:** an abort can coincide with a marker rendezvous. The bench presents both markers with the abort high. It expects both markers to stay held and the mode to stay loading. One cycle later, without the abort, it expects the rendezvous to complete.

A reference model in the bench runs alongside random mixes of markers, ordinary items, backpressure and aborts. It judges every cycle against the model.

// File: rtl/lrq_pkg.sv
// Package: shared constants and types for the loop requeue controller.
// Assumes the marker opcode sits in a fixed field of the instruction word.
package lrq_pkg;
    parameter int INSTR_W      = 25;
    parameter int OPC_MSB      = 21;
    parameter int OPC_LSB      = 18;
    localparam int OPC_W       = OPC_MSB - OPC_LSB + 1;
    parameter logic [OPC_W-1:0] START_CODE = 4'b1110;
    parameter logic [OPC_W-1:0] END_CODE   = 4'b1111;

    // Controller mode
    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_SPIN = 1'b1
    } lrq_mode_e;
endpackage

// File: rtl/lrq_marker_decode.sv
// Module: lrq_marker_decode
// Flags an instruction whose opcode field equals one marker code.
// Assumes: pure combinational, validity is qualified by the caller.
module lrq_marker_decode #(
    parameter int DATA_W = 25,
    parameter int MSB    = 21,
    parameter int LSB    = 18,
    parameter int CODE_W = MSB - LSB + 1,
    parameter logic [CODE_W-1:0] CODE = '1
) (
    input  logic [DATA_W-1:0] instr,
    output logic              is_marker
);
    // Compare the opcode field against the marker code
    always_comb begin
        is_marker = (instr[MSB:LSB] == CODE);
    end
endmodule

// File: rtl/lrq_mode_fsm.sv
// Module: lrq_mode_fsm
// Holds the loading/looping mode bit. A rendezvous enters looping mode
// and an abort leaves it. Assumes the rendezvous input is already
// suppressed by abort and only asserts in loading mode.
module lrq_mode_fsm
    import lrq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rendezvous,
    input  logic abort_pulse,
    output logic loop_active
);
    lrq_mode_e mode_q, mode_d;

    // Next-mode selection: abort has priority over entry
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LOAD: if (rendezvous && !abort_pulse) mode_d = MODE_SPIN;
            MODE_SPIN: if (abort_pulse) mode_d = MODE_LOAD;
            default:   mode_d = MODE_LOAD;
        endcase
    end

    // Mode register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_LOAD;
        else        mode_q <= mode_d;
    end

    assign loop_active = (mode_q == MODE_SPIN);

    // R5
    enter_spin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && rendezvous) |=> loop_active);
    // R7
    abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && abort_pulse) |=> !loop_active);
    // R8
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && abort_pulse) |=> !loop_active);
endmodule

// File: rtl/lrq_route.sv
// Module: lrq_route
// Steers the load and return streams onto the FIFO stream according to
// the mode, and detects the marker rendezvous. Combinational. The clock
// and reset inputs serve only the local assertions.
module lrq_route #(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_active,
    input  logic              abort_pulse,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_is_end,
    output logic              load_ready,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    input  logic              ret_is_start,
    output logic              ret_ready,
    output logic              fifo_valid,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_ready,
    output logic              rendezvous
);
    logic end_held, start_held;

    // Markers waiting at their inputs in loading mode
    always_comb begin
        end_held   = !loop_active && load_valid && load_is_end;
        start_held = !loop_active && ret_valid  && ret_is_start;
        rendezvous = end_held && start_held && !abort_pulse;
    end

    // Handshake steering for both modes
    always_comb begin
        if (loop_active) begin
            load_ready = 1'b0;
            ret_ready  = fifo_ready;
            fifo_valid = ret_valid;
            fifo_data  = ret_data;
        end else begin
            load_ready = load_is_end  ? rendezvous : fifo_ready;
            ret_ready  = ret_is_start ? rendezvous : 1'b1;
            fifo_valid = load_valid && !load_is_end;
            fifo_data  = load_data;
        end
    end

    // R6
    spin_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> !load_ready);
    // R3
    drop_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && ret_valid && !ret_is_start) |-> ret_ready);
    // R4
    end_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_held && !rendezvous) |-> (!load_ready && !fifo_valid));
    // R9
    dual_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && ret_valid && !ret_is_start && load_valid
         && !load_is_end && fifo_ready) |-> (ret_ready && load_ready));
endmodule

// File: rtl/loop_requeue_ctrl.sv
// Module: loop_requeue_ctrl (top)
// Requeue controller in front of a circular instruction FIFO. Decodes
// the loop markers, steers the streams and holds the mode.
// Assumes: abort_pulse is already qualified by its predicate, and the
// upstream sources hold their data while valid and not ready.
module loop_requeue_ctrl
    import lrq_pkg::*;
#(
    parameter int DATA_W = INSTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ready,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    output logic              ret_ready,
    output logic              fifo_valid,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_ready,
    input  logic              abort_pulse,
    output logic              loop_active
);
    localparam int NSIDE = 2;

    logic [DATA_W-1:0] side_data [NSIDE];
    logic [NSIDE-1:0]  side_marker;
    logic              rendezvous;

    assign side_data[0] = load_data;
    assign side_data[1] = ret_data;

    // One decoder per stream: loop-end on load, loop-start on return
    for (genvar s = 0; s < NSIDE; s++) begin : g_dec
        lrq_marker_decode #(
            .DATA_W (DATA_W),
            .MSB    (OPC_MSB),
            .LSB    (OPC_LSB),
            .CODE_W (OPC_W),
            .CODE   ((s == 0) ? END_CODE : START_CODE)
        ) u_dec (
            .instr     (side_data[s]),
            .is_marker (side_marker[s])
        );
    end

    lrq_route #(.DATA_W(DATA_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_active  (loop_active),
        .abort_pulse  (abort_pulse),
        .load_valid   (load_valid),
        .load_data    (load_data),
        .load_is_end  (side_marker[0]),
        .load_ready   (load_ready),
        .ret_valid    (ret_valid),
        .ret_data     (ret_data),
        .ret_is_start (side_marker[1]),
        .ret_ready    (ret_ready),
        .fifo_valid   (fifo_valid),
        .fifo_data    (fifo_data),
        .fifo_ready   (fifo_ready),
        .rendezvous   (rendezvous)
    );

    lrq_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rendezvous  (rendezvous),
        .abort_pulse (abort_pulse),
        .loop_active (loop_active)
    );

    // R2
    load_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_active && load_valid && load_data[OPC_MSB:OPC_LSB] != END_CODE)
        |-> (fifo_valid && fifo_data == load_data && load_ready == fifo_ready));
    // R6
    spin_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && ret_valid) |-> (fifo_valid && fifo_data == ret_data));
endmodule

// File: tb/loop_requeue_ctrl_tb_top.sv
`timescale 1ns/1ps
module loop_requeue_ctrl_tb_top;
    localparam int W = 25;
    localparam logic [3:0] C_START = 4'b1110;
    localparam logic [3:0] C_END   = 4'b1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_valid = 1'b0, ret_valid = 1'b0, fifo_ready = 1'b0, abort_pulse = 1'b0;
    logic [W-1:0] load_data = '0, ret_data = '0;
    logic load_ready, ret_ready, fifo_valid, loop_active;
    logic [W-1:0] fifo_data;

    int tests = 0;
    int fails = 0;
    bit model_spin = 1'b0;
    bit model_next = 1'b0;

    always #2 clk = ~clk;

    loop_requeue_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_data(load_data), .load_ready(load_ready),
        .ret_valid(ret_valid), .ret_data(ret_data), .ret_ready(ret_ready),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
        .abort_pulse(abort_pulse), .loop_active(loop_active)
    );

    function automatic logic [W-1:0] mk(input logic [3:0] opc, input logic [20:0] rest);
        logic [W-1:0] v;
        v = {3'b010, opc, 18'd0} | {4'd0, 3'd0, rest[17:0]};
        v[24:22] = rest[20:18];
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle, compare all outputs with the model, advance the model
    task automatic step(input logic ev, input logic [W-1:0] ed, input logic rv,
                        input logic [W-1:0] rd, input logic fr, input logic ab, input string tag);
        bit is_end, is_start, meet;
        logic e_fv, e_lr, e_rr;
        logic [W-1:0] e_fd;
        @(negedge clk);
        load_valid = ev; load_data = ed; ret_valid = rv; ret_data = rd;
        fifo_ready = fr; abort_pulse = ab;
        #1;
        is_end   = (ed[21:18] == C_END);
        is_start = (rd[21:18] == C_START);
        chk(tag, "loop_active", W'(loop_active), W'(model_spin));
        if (!model_spin) begin
            meet = ev && rv && is_end && is_start && !ab;
            e_fv = ev && !is_end; e_fd = ed;
            e_lr = is_end ? meet : fr;
            e_rr = is_start ? meet : 1'b1;
            model_next = meet;
        end else begin
            e_fv = rv; e_fd = rd; e_lr = 1'b0; e_rr = fr;
            model_next = !ab;
        end
        chk(tag, "fifo_valid", W'(fifo_valid), W'(e_fv));
        if (e_fv) chk(tag, "fifo_data", fifo_data, e_fd);
        if (ev || model_spin) chk(tag, "load_ready", W'(load_ready), W'(e_lr));
        if (rv) chk(tag, "ret_ready", W'(ret_ready), W'(e_rr));
        @(posedge clk);
        model_spin = model_next;
    endtask

    logic [W-1:0] ord_a, ord_b, endm, startm;

    initial begin
        ord_a  = mk(4'b0101, 21'h0ABCD);
        ord_b  = mk(4'b1101, 21'h13579);
        endm   = mk(C_END, 21'h00F0F);
        startm = mk(C_START, 21'h1F00F);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state visible at the ports
        chk("R1", "loop_active in reset", W'(loop_active), W'(0));
        @(negedge clk); rst_n = 1'b1;
        step(0, '0, 0, '0, 1, 0, "R1");
        // R2: forward ordinary load item, with and without backpressure
        step(1, ord_a, 0, '0, 1, 0, "R2");
        step(1, ord_a, 0, '0, 0, 0, "R2");
        // R3: ordinary return item is dropped
        step(0, '0, 1, ord_b, 0, 0, "R3");
        // R9: drop and forward in one cycle
        step(1, ord_a, 1, ord_b, 1, 0, "R9");
        // R4: lone markers stall
        step(1, endm, 0, '0, 1, 0, "R4");
        step(1, endm, 1, ord_a, 1, 0, "R4");
        step(0, '0, 1, startm, 1, 0, "R4");
        step(1, ord_a, 1, startm, 1, 0, "R4");
        // R8: abort blocks rendezvous
        step(1, endm, 1, startm, 1, 1, "R8");
        // R5: rendezvous enters looping mode
        step(1, endm, 1, startm, 1, 0, "R5");
        // R6: looping passes returns incl. markers, load blocked
        step(1, ord_a, 1, startm, 1, 0, "R6");
        step(1, endm, 1, endm, 1, 0, "R6");
        step(0, '0, 1, ord_b, 0, 0, "R6");
        // R7: abort exits, then abort in loading does nothing
        step(0, '0, 1, ord_b, 1, 1, "R7");
        step(0, '0, 0, '0, 1, 1, "R7");
        step(1, ord_b, 0, '0, 1, 0, "R7");
        // R10: other codes ordinary; marker codes on wrong stream ordinary
        step(1, ord_b, 1, endm, 1, 0, "R10");
        step(1, startm, 0, '0, 1, 0, "R10");
        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, b;
            int ka, kb;
            ka = $urandom_range(0, 2); kb = $urandom_range(0, 2);
            a = mk(ka == 0 ? C_END : (ka == 1 ? C_START : 4'($urandom)), 21'($urandom));
            b = mk(kb == 0 ? C_START : (kb == 1 ? C_END : 4'($urandom)), 21'($urandom));
            step(1'($urandom), a, 1'($urandom), b, 1'($urandom),
                 ($urandom_range(0, 9) == 0), model_spin ? "R6" : "R2");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule